// File: doc/BRIEF.md
# Utility Interrupt Vector Register

This block is a byte-wide register that gives the local CPU an interrupt vector for a bank of up to eight on-chip utility interrupt sources. Software programs the upper five bits as a vector base. Hardware supplies the lower three bits, and their meaning depends on the cycle type.

During an interrupt acknowledge cycle, the low bits echo the CPU acknowledge address lines (A3..A1). The acknowledged level therefore becomes the source ID inside the vector. During an ordinary register read, the low bits return a fixed register offset.

The base may not be altered while any utility source is active. The block enforces this by dropping base writes whenever any bit of the source-active input is set. Read data is registered and appears one cycle after the strobe, together with a valid flag.

Top module: `util_vec_reg`

## Requirements
- R1: While rst_ni is low, rdata_o is 0x00, rvalid_o is 0 and the base is cleared. A normal read after reset returns 0x01.
- R2: A write cycle is sel_i=1, we_i=1, iack_i=0. When no source is active, it loads wdata_i[7:3] into the base, and later reads return that base in bits 7:3.
- R3: Bits 2:0 of wdata_i have no effect on any later read value.
- R4: An acknowledge cycle is sel_i=1, we_i=0, iack_i=1. One cycle later, rdata_o equals {base, addr_i} as sampled in the strobe cycle, where addr_i[2:0] carries A3..A1.
- R5: A normal read is sel_i=1, we_i=0, iack_i=0. One cycle later, rdata_o equals {base, 3'b001}, whatever the value of addr_i.
- R6: A write cycle while any bit of src_active_i is 1 leaves the base unchanged.
- R7: rvalid_o is 1 in exactly the cycle after each read or acknowledge strobe and 0 otherwise. rdata_o is 0x00 whenever rvalid_o is 0.
- R8: A write cycle does not raise rvalid_o in the next cycle.
- R9: A cycle with sel_i=1, we_i=1 and iack_i=1 neither changes the base nor raises rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| iack_i | input | 1 | Qualifies the access as an interrupt acknowledge |
| addr_i | input | 3 | CPU address lines A3..A1 |
| wdata_i | input | 8 | Write data |
| src_active_i | input | 8 | Per-source active flags |
| rdata_o | output | 8 | Registered read or vector data |
| rvalid_o | output | 1 | rdata_o is valid this cycle |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the zero data when idle;
- the low-bit selection between the echoed address and the fixed offset;
- the freeze of the base while sources are active or a write is combined with an acknowledge;
- the loading of the base on a permitted write.

Only the bench scenarios can show that a sequence behaves end to end. Examples are that a value written earlier reappears in later vectors, that the low write bits never resurface, and that an asynchronous reset in mid-run restores the cleared base.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_WRITE,
    CYC_READ,
    CYC_IACK,
    CYC_BAD
  } cyc_e;
endpackage

// File: rtl/uvr_cyc_dec.sv
module uvr_cyc_dec
  import uvr_pkg::*;
(
  input  logic sel_i,
  input  logic we_i,
  input  logic iack_i,
  output cyc_e cyc_o
);
  always_comb begin
    cyc_o = CYC_IDLE;
    if (sel_i) begin
      unique case ({we_i, iack_i})
        2'b10:   cyc_o = CYC_WRITE;
        2'b00:   cyc_o = CYC_READ;
        2'b01:   cyc_o = CYC_IACK;
        default: cyc_o = CYC_BAD; // write during acknowledge: dropped
      endcase
    end
  end

  // R9: a write strobe together with an acknowledge never decodes as a write
  always_comb begin
    if (sel_i && we_i && iack_i) a_r9_no_write_in_iack: assert (cyc_o == CYC_BAD);
  end
endmodule

// File: rtl/uvr_base_reg.sv
module uvr_base_reg
  import uvr_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ID_W   = 3,
  parameter int N_SRC  = 8,
  localparam int BASE_W = VEC_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic [VEC_W-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  src_active_i,
  output logic [BASE_W-1:0] base_o
);
  logic any_active;
  logic wr_ok;
  logic unused_low;

  assign any_active = |src_active_i;
  assign wr_ok      = (cyc_i == CYC_WRITE) && !any_active;
  assign unused_low = ^wdata_i[ID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_o <= '0;
    else if (wr_ok) base_o <= wdata_i[VEC_W-1:ID_W];
  end

  a_r6_hold_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_active_i) |=> $stable(base_o));

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_WRITE && src_active_i == '0) |=> base_o == $past(wdata_i[VEC_W-1:ID_W]));

  a_r9_bad_cycle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_BAD) |=> $stable(base_o));
endmodule

// File: rtl/uvr_vec_out.sv
module uvr_vec_out
  import uvr_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int ID_W  = 3,
  parameter logic [ID_W-1:0] REG_OFFSET = 3'b001,
  localparam int BASE_W = VEC_W - ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [ID_W-1:0]   addr_i,
  output logic [VEC_W-1:0]  rdata_o,
  output logic              rvalid_o
);
  logic            ld;
  logic [ID_W-1:0] low_bits;

  assign ld       = (cyc_i == CYC_READ) || (cyc_i == CYC_IACK);
  assign low_bits = (cyc_i == CYC_IACK) ? addr_i : REG_OFFSET;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= ld;
      rdata_o  <= ld ? {base_i, low_bits} : '0;
    end
  end

  a_r7_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_READ || cyc_i == CYC_IACK) |=> rvalid_o);

  a_r7_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i == CYC_READ || cyc_i == CYC_IACK) |=> !rvalid_o);

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);

  a_r4_iack_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_IACK) |=> rdata_o[ID_W-1:0] == $past(addr_i));

  a_r5_read_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_READ) |=> rdata_o[ID_W-1:0] == REG_OFFSET);

  a_r2_base_in_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_READ || cyc_i == CYC_IACK) |=> rdata_o[VEC_W-1:ID_W] == $past(base_i));
endmodule

// File: rtl/util_vec_reg.sv
module util_vec_reg
  import uvr_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int ID_W  = 3,
  parameter int N_SRC = 8,
  parameter logic [ID_W-1:0] REG_OFFSET = 3'b001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             iack_i,
  input  logic [ID_W-1:0]  addr_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [N_SRC-1:0] src_active_i,
  output logic [VEC_W-1:0] rdata_o,
  output logic             rvalid_o
);
  localparam int BASE_W = VEC_W - ID_W;

  cyc_e              cyc;
  logic [BASE_W-1:0] base_q;

  uvr_cyc_dec u_dec (
    .sel_i  (sel_i),
    .we_i   (we_i),
    .iack_i (iack_i),
    .cyc_o  (cyc)
  );

  uvr_base_reg #(.VEC_W(VEC_W), .ID_W(ID_W), .N_SRC(N_SRC)) u_base (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_i        (cyc),
    .wdata_i      (wdata_i),
    .src_active_i (src_active_i),
    .base_o       (base_q)
  );

  uvr_vec_out #(.VEC_W(VEC_W), .ID_W(ID_W), .REG_OFFSET(REG_OFFSET)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_i    (cyc),
    .base_i   (base_q),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  a_r8_write_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i) |=> !rvalid_o);
endmodule

// File: tb/util_vec_reg_tb.sv
module util_vec_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, iack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, act = '0;
  logic [7:0] rdata;
  logic       rvalid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  util_vec_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .iack_i(iack),
    .addr_i(addr), .wdata_i(wdata), .src_active_i(act),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // kind: 0 write, 1 normal read, 2 acknowledge | data | addr | active | expected
  localparam logic [28:0] TBL [14] = '{
    {2'd0, 8'hA5, 3'd0, 8'h00, 8'h00},  // R2
    {2'd1, 8'h00, 3'd0, 8'h00, 8'hA1},  // R5
    {2'd1, 8'h00, 3'd7, 8'h00, 8'hA1},  // R5 addr ignored
    {2'd2, 8'h00, 3'd3, 8'h00, 8'hA3},  // R4
    {2'd2, 8'h00, 3'd7, 8'h00, 8'hA7},  // R4
    {2'd0, 8'h3F, 3'd0, 8'h10, 8'h00},  // R6 blocked
    {2'd1, 8'h00, 3'd2, 8'h00, 8'hA1},  // R6
    {2'd0, 8'h3F, 3'd0, 8'h00, 8'h00},  // R2
    {2'd1, 8'h00, 3'd0, 8'h00, 8'h39},  // R3
    {2'd2, 8'h00, 3'd0, 8'h00, 8'h38},  // R4
    {2'd0, 8'hFF, 3'd0, 8'h80, 8'h00},  // R6 blocked
    {2'd2, 8'h00, 3'd5, 8'h00, 8'h3D},  // R6
    {2'd0, 8'h07, 3'd0, 8'h00, 8'h00},  // R3
    {2'd1, 8'h00, 3'd6, 8'h00, 8'h01}   // R3
  };

  task automatic check(input string req, input logic [8:0] act_v, input logic [8:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual {valid,data}=%h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic [7:0] a, input logic ia);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; iack = ia; wdata = d; act = a;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; iack = 1'b0; act = '0;
    check("R8", {rvalid, rdata}, 9'h000);
  endtask

  task automatic do_read(input logic ia, input logic [2:0] ad, input logic [7:0] e, input string req);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; iack = ia; addr = ad;
    @(negedge clk);
    sel = 1'b0; iack = 1'b0;
    check(req, {rvalid, rdata}, {1'b1, e});
  endtask

  initial begin
    #1;
    check("R1", {rvalid, rdata}, 9'h000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    do_read(1'b0, 3'd4, 8'h01, "R1");
    @(negedge clk);
    check("R7", {rvalid, rdata}, 9'h000);

    for (int i = 0; i < 14; i++) begin
      if (TBL[i][28:27] == 2'd0)
        do_write(TBL[i][26:19], TBL[i][15:8], 1'b0);
      else
        do_read(TBL[i][28:27] == 2'd2, TBL[i][18:16], TBL[i][7:0], "R2/R3/R4/R5/R6 table");
    end

    do_write(8'hC8, 8'h00, 1'b0);
    do_write(8'h18, 8'h00, 1'b1);  // R9
    do_read(1'b0, 3'd0, 8'hC9, "R9");

    // R7: back-to-back strobes keep valid high; it drops right after
    @(negedge clk);
    sel = 1'b1; we = 1'b0; iack = 1'b1; addr = 3'd2;
    @(negedge clk);
    check("R7", {rvalid, rdata}, 9'h1CA);
    iack = 1'b0;
    @(negedge clk);
    check("R7", {rvalid, rdata}, 9'h1C9);
    sel = 1'b0;
    @(negedge clk);
    check("R7", {rvalid, rdata}, 9'h000);

    // R1: asynchronous reset in mid-run clears the base
    #2 rst_n = 1'b0;
    #1 check("R1", {rvalid, rdata}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    do_read(1'b0, 3'd1, 8'h01, "R1");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule